// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a host polls while a flash device carries out a program or erase operation. The command decoder next to it issues one-cycle start pulses: a program pulse together with the data byte being written, a sector-erase pulse or a chip-erase pulse. The block updates the status byte, runs a busy counter for the duration of an erase, and raises a one-cycle done pulse when the erase ends. The decoder uses that pulse to return to idle or to its command-wait state. The array contents and the command decoding are outside this block.

Status reads arrive on a level strobe. The block acts once on the rising edge of that strobe. It captures the current status byte into a read-data register, then inverts the toggle bit (bit 6). A host can therefore tell that an operation is running by reading twice and comparing. Bit 7 is the polling bit. A program sets it to the complement of bit 7 of the written data. An erase clears it, and it flips when the erase timer expires. The erase durations are parameters counted in clock cycles. A chip erase lasts a fixed multiple of the sector-erase duration, ten times by default.

Top module: `flash_op_status`

## Requirements
- R1: After synchronous reset, status_o is 0x00, rd_data_o is 0x00, and busy_o and done_o are 0.
- R2: A rising edge of stat_rd_i copies the current status into rd_data_o and inverts status bit 6. Both changes are visible one cycle after the first cycle in which the strobe is high.
- R3: A strobe held high for several cycles counts as a single read. Bit 6 is inverted only once, and status does not change while nothing else happens.
- R4: An accepted program pulse sets the status to 0x7F with bit 7 equal to the inverse of prog_data_i bit 7 (0x00→0xFF, 0x80→0x7F). busy_o stays 0.
- R5: An accepted sector or chip erase pulse clears the status to 0x00 and raises busy_o in the next cycle.
- R6: busy_o stays high for exactly SECT_CYCLES cycles for a sector erase and for SECT_CYCLES*CHIP_MULT cycles for a chip erase.
- R7: In the first cycle after busy_o falls, done_o is high for exactly one cycle and status bit 7 has been inverted, with the other bits unchanged.
- R8: While busy_o is high, program, sector-erase and chip-erase pulses are ignored. The status does not change and the erase length does not change.
- R9: When several start pulses coincide, chip erase takes priority over sector erase, and sector erase takes priority over program.
- R10: When a read edge coincides with an accepted start pulse, rd_data_o captures the old status and the start pulse sets the new status. No bit-6 inversion is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start_i | input | 1 | One-cycle program start pulse |
| prog_data_i | input | 8 | Data byte of the program operation |
| sect_erase_i | input | 1 | One-cycle sector-erase start pulse |
| chip_erase_i | input | 1 | One-cycle chip-erase start pulse |
| stat_rd_i | input | 1 | Status read strobe (level; acts on rising edge) |
| status_o | output | 8 | Current status byte (registered) |
| rd_data_o | output | 8 | Status byte captured by the last read |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle erase-complete pulse |

## Verification
Every start pulse and every read edge passes through one register stage. Status, read data and busy are therefore due one clock after the cycle in which the input is high. Inputs are driven on the falling edge, and outputs are sampled on the next falling edge. Erase length is measured by counting the falling edges on which busy_o is high, beginning with the first one after the start edge. Done and the flipped polling bit are checked on the first falling edge with busy_o low, and done is checked low again one edge later.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int STAT_W     = 8;
  localparam int TOGGLE_BIT = 6;
  localparam int POLL_BIT   = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } fsg_op_e;
endpackage

// File: rtl/fsg_rd_edge.sv
module fsg_rd_edge (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  output logic rd_evt_o
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_i;
  end

  assign rd_evt_o = rd_i & ~rd_q;

  // A held strobe gives one event only
  assert_single_event_R3: assert property (@(posedge clk) disable iff (rst)
    rd_evt_o |=> !rd_evt_o);
endmodule

// File: rtl/fsg_erase_timer.sv
module fsg_erase_timer #(
  parameter int SECT_CYCLES = 1000,
  parameter int CHIP_MULT   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  fsg_pkg::fsg_op_e op_i,
  output logic            busy_o,
  output logic            expire_o,
  output logic            done_o
);
  import fsg_pkg::*;

  localparam int CHIP_CYCLES = SECT_CYCLES * CHIP_MULT;
  localparam int CNT_W       = $clog2(CHIP_CYCLES + 1);
  localparam logic [CNT_W-1:0] SECT_LOAD = CNT_W'(SECT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign expire_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= expire_o;
      if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (op_i == OP_SECT) begin
        cnt_q  <= SECT_LOAD;
        busy_q <= 1'b1;
      end else if (op_i == OP_CHIP) begin
        cnt_q  <= CHIP_LOAD;
        busy_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_count_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_busy_end_done_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/fsg_status_reg.sv
module fsg_status_reg (
  input  logic                       clk,
  input  logic                       rst,
  input  fsg_pkg::fsg_op_e           op_i,
  input  logic [fsg_pkg::STAT_W-1:0] data_i,
  input  logic                       rd_evt_i,
  input  logic                       expire_i,
  output logic [fsg_pkg::STAT_W-1:0] status_o,
  output logic [fsg_pkg::STAT_W-1:0] rd_data_o
);
  import fsg_pkg::*;

  localparam logic [STAT_W-1:0] POLL_MASK = STAT_W'(1) << POLL_BIT;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] rd_q;
  logic [STAT_W-1:0] flip_mask;

  always_comb begin
    flip_mask = '0;
    flip_mask[TOGGLE_BIT] = rd_evt_i;
    flip_mask[POLL_BIT]   = expire_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      rd_q   <= '0;
    end else begin
      if (rd_evt_i) rd_q <= stat_q;
      case (op_i)
        OP_PROG:          stat_q <= ~(data_i & POLL_MASK);
        OP_SECT, OP_CHIP: stat_q <= '0;
        default:          stat_q <= stat_q ^ flip_mask;
      endcase
    end
  end

  assign status_o  = stat_q;
  assign rd_data_o = rd_q;

  assert_toggle_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE && rd_evt_i) |=> (stat_q[TOGGLE_BIT] != $past(stat_q[TOGGLE_BIT])));
  assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE && !rd_evt_i && !expire_i) |=> $stable(stat_q));
  assert_prog_status_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PROG) |=> (stat_q[TOGGLE_BIT] && stat_q[POLL_BIT] == !$past(data_i[POLL_BIT])));
  assert_erase_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SECT || op_i == OP_CHIP) |=> (stat_q == '0));
  assert_poll_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE && expire_i) |=> (stat_q[POLL_BIT] != $past(stat_q[POLL_BIT])));
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status #(
  parameter int SECT_CYCLES = 1000,
  parameter int CHIP_MULT   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       prog_start_i,
  input  logic [7:0] prog_data_i,
  input  logic       sect_erase_i,
  input  logic       chip_erase_i,
  input  logic       stat_rd_i,
  output logic [7:0] status_o,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       done_o
);
  import fsg_pkg::*;

  fsg_op_e op;
  logic    rd_evt;
  logic    expire;
  logic    busy;

  // Accept a start only when idle; chip > sector > program
  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (chip_erase_i)      op = OP_CHIP;
      else if (sect_erase_i) op = OP_SECT;
      else if (prog_start_i) op = OP_PROG;
    end
  end

  fsg_rd_edge u_rd_edge (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (stat_rd_i),
    .rd_evt_o (rd_evt)
  );

  fsg_erase_timer #(
    .SECT_CYCLES (SECT_CYCLES),
    .CHIP_MULT   (CHIP_MULT)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .busy_o   (busy),
    .expire_o (expire),
    .done_o   (done_o)
  );

  fsg_status_reg u_status (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .data_i    (prog_data_i),
    .rd_evt_i  (rd_evt),
    .expire_i  (expire),
    .status_o  (status_o),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;

  assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && (prog_start_i || sect_erase_i)) |=> $stable(status_o) || $past(rd_evt) || $past(expire));
endmodule

// File: tb/flash_op_status_tb.sv
module flash_op_status_tb;
  localparam int SECT = 20;
  localparam int MULT = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_start_i = 1'b0;
  logic [7:0] prog_data_i = 8'h00;
  logic       sect_erase_i = 1'b0;
  logic       chip_erase_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic [7:0] status_o, rd_data_o;
  logic       busy_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_op_status #(.SECT_CYCLES(SECT), .CHIP_MULT(MULT)) u_dut (
    .clk(clk), .rst(rst), .prog_start_i(prog_start_i), .prog_data_i(prog_data_i),
    .sect_erase_i(sect_erase_i), .chip_erase_i(chip_erase_i), .stat_rd_i(stat_rd_i),
    .status_o(status_o), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o));

  // {kind(1=read,0=program), data, expected status, expected read data}
  localparam logic [24:0] VEC [0:7] = '{
    {1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hBF, 8'hFF},
    {1'b1, 8'h00, 8'hFF, 8'hBF},
    {1'b0, 8'h80, 8'h7F, 8'h00},
    {1'b1, 8'h00, 8'h3F, 8'h7F},
    {1'b0, 8'h5A, 8'hFF, 8'h00},
    {1'b0, 8'hC3, 8'h7F, 8'h00},
    {1'b1, 8'h00, 8'h3F, 8'h7F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Counts the busy cycles after a start edge and returns that count
  task automatic run_busy(output int n, input bit inject);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      if (inject) begin
        if (n == 2) begin prog_start_i = 1'b1; prog_data_i = 8'hFF; end
        if (n == 3) begin
          chk("R8 program ignored while busy", status_o, 8'h00);
          prog_start_i = 1'b0; chip_erase_i = 1'b1;
        end
        if (n == 4) chip_erase_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status reset", status_o, 8'h00);
    chk("R1 read data reset", rd_data_o, 8'h00);
    chk("R1 busy/done reset", {busy_o, done_o}, 2'b00);

    // Table walk: programs (R4) and single reads (R2)
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][24]) begin
        stat_rd_i = 1'b1;
        @(negedge clk);
        chk("R2 read captures status", rd_data_o, VEC[i][7:0]);
        chk("R2 toggle bit inverted", status_o, VEC[i][15:8]);
        stat_rd_i = 1'b0;
        @(negedge clk);
      end else begin
        prog_start_i = 1'b1; prog_data_i = VEC[i][23:16];
        @(negedge clk);
        prog_start_i = 1'b0;
        chk("R4 program status", status_o, VEC[i][15:8]);
        chk("R4 program not busy", busy_o, 1'b0);
      end
    end

    // R3: held strobe toggles once (status 3F -> 7F)
    stat_rd_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 held read single toggle", status_o, 8'h7F);
    stat_rd_i = 1'b0;
    @(negedge clk);

    // Sector erase with ignored starts (R5, R6, R7, R8)
    sect_erase_i = 1'b1;
    @(negedge clk);
    sect_erase_i = 1'b0;
    chk("R5 erase clears status", status_o, 8'h00);
    chk("R5 busy raised", busy_o, 1'b1);
    run_busy(n, 1'b1);
    chk("R6/R8 sector erase length", n, SECT);
    chk("R7 done after sector erase", done_o, 1'b1);
    chk("R7 poll bit flipped", status_o, 8'h80);
    @(negedge clk);
    chk("R7 done one cycle", done_o, 1'b0);

    // Chip erase with a read during busy
    chip_erase_i = 1'b1;
    @(negedge clk);
    chip_erase_i = 1'b0;
    chk("R5 chip erase clears status", status_o, 8'h00);
    repeat (4) @(negedge clk);
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
    chk("R2 read during erase", rd_data_o, 8'h00);
    chk("R2 toggle during erase", status_o, 8'h40);
    run_busy(n, 1'b0);
    chk("R6 chip erase length", n + 5, SECT * MULT);
    chk("R7 chip erase done and flip", {done_o, status_o}, {1'b1, 8'hC0});
    @(negedge clk);

    // R9 priorities
    prog_start_i = 1'b1; sect_erase_i = 1'b1; chip_erase_i = 1'b1; prog_data_i = 8'h00;
    @(negedge clk);
    prog_start_i = 1'b0; sect_erase_i = 1'b0; chip_erase_i = 1'b0;
    chk("R9 chip wins status", status_o, 8'h00);
    run_busy(n, 1'b0);
    chk("R9 chip wins length", n, SECT * MULT);
    @(negedge clk);
    prog_start_i = 1'b1; sect_erase_i = 1'b1;
    @(negedge clk);
    prog_start_i = 1'b0; sect_erase_i = 1'b0;
    chk("R9 sector beats program", status_o, 8'h00);
    run_busy(n, 1'b0);
    chk("R9 sector length", n, SECT);
    chk("R9 status after sector", status_o, 8'h80);
    @(negedge clk);

    // R10 read coincident with program
    stat_rd_i = 1'b1; prog_start_i = 1'b1; prog_data_i = 8'h80;
    @(negedge clk);
    stat_rd_i = 1'b0; prog_start_i = 1'b0;
    chk("R10 read gets old status", rd_data_o, 8'h80);
    chk("R10 program wins, no toggle", status_o, 8'h7F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule